// File: doc/BRIEF.md
# Panel Power Sequencer

This block decides when a flat-panel module's logic supply, its video interface drive and its backlight lamp are switched on and off. A system controller raises a single power request. The sequencer then brings the three enables up in a fixed order and takes them down in the reverse order. It watches a power-good indication from the logic supply and stops with a fault if that indication is late or lost.

All intervals are counted in pulses of a millisecond tick input. The tick rate is chosen by the surrounding system, so a bench can compress time. Each interval is a parameter. A pulse of `ms_tick` is counted on a clock edge where it is high and the sequencer is not changing step on that same edge. A tick that falls on a step-change edge is not counted, so every interval spans whole ticks.

The sequencer separates the interface drive from the lamp by a long settling interval. It keeps short, separate hold intervals on the way down. It also holds the logic supply off for a minimum recovery time before any restart.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `vdd_en`, `drv_en`, `lamp_en` and `supply_fault` are all 0.
- R2: If the off-recovery time has already elapsed, `vdd_en` rises on the clock edge that follows the first edge sampling `pwr_req` high. The first request after reset counts as recovered.
- R3: During the supply ramp, `drv_en` rises on the clock edge after the first edge that samples `vdd_good` high, with no added delay. `drv_en` never rises unless `vdd_good` was high on the edge before.
- R4: If `vdd_good` has not been seen after `VDD_GOOD_MAX_MS` counted ticks of ramp, `supply_fault` rises on the edge after the last counted tick. All three enables drop on that same edge.
- R5: `lamp_en` rises on the edge after `LAMP_DELAY_MS` ticks have been counted since `drv_en` rose.
- R6: When `pwr_req` is sampled low with the lamp on, `lamp_en` falls on the next edge while `drv_en` stays on. `drv_en` falls after `LAMP_HOLD_MS` counted ticks, and `vdd_en` falls after a further `DRV_HOLD_MS` counted ticks.
- R7: A request drop during the ramp turns `vdd_en` off on the next edge. A request drop while waiting for the lamp turns `drv_en` off on the next edge, and `vdd_en` follows after `DRV_HOLD_MS` ticks. The lamp does not turn on in either case.
- R8: Once the lamp has been turned off for power-down, raising `pwr_req` again does not stop the power-down order. The lamp stays off and the later steps keep their schedule.
- R9: After `vdd_en` falls, it does not rise again until at least `OFF_RECOVER_MS` ticks have been counted. With the request held high, it rises on the edge after exactly that count.
- R10: `supply_fault` stays high with all enables low for as long as `pwr_req` stays high. It clears on the edge after `pwr_req` is sampled low.
- R11: If `vdd_good` is sampled low while `drv_en` is high, `supply_fault` rises on the next edge and all enables drop on that same edge.
- R12: At all times `lamp_en` implies `drv_en`, and `drv_en` implies `vdd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond (the time base) |
| pwr_req | input | 1 | Panel on request, level |
| vdd_good | input | 1 | Logic supply has reached its good level |
| vdd_en | output | 1 | Logic supply enable |
| drv_en | output | 1 | Video interface drive enable; interface held low or high-impedance when 0 |
| lamp_en | output | 1 | Backlight lamp enable |
| supply_fault | output | 1 | Logic supply failed to come up or was lost |

## Verification
Every output is decoded from the step register, so a response to `pwr_req` or `vdd_good` appears one edge after that input is first sampled. The bench drives inputs just after a rising edge and records output changes at the following falling edges, so it expects each such response exactly one recorded cycle after the one in which the input was first visible. A timed result appears on the edge after its last counted tick. The bench keeps a running tick count at each falling edge and requires that the ticks seen between two output changes equal the parameter exactly. The tick pulses are spaced four cycles apart, so no tick can fall on the step-change edge and that count is exact.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_RAMP     = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_ON       = 3'd3,
        ST_LAMP_DN  = 3'd4,
        ST_DRV_DN   = 3'd5,
        ST_FAULT    = 3'd6
    } pps_state_e;

    typedef struct packed {
        logic supply;
        logic drive;
        logic lamp;
        logic fault;
    } pps_out_t;

    function automatic pps_out_t pps_decode(pps_state_e s);
        pps_out_t o;
        o = '0;
        case (s)
            ST_RAMP:    o.supply = 1'b1;
            ST_SETTLE:  begin o.supply = 1'b1; o.drive = 1'b1; end
            ST_ON:      begin o.supply = 1'b1; o.drive = 1'b1; o.lamp = 1'b1; end
            ST_LAMP_DN: begin o.supply = 1'b1; o.drive = 1'b1; end
            ST_DRV_DN:  o.supply = 1'b1;
            ST_FAULT:   o.fault = 1'b1;
            default:    o = '0;
        endcase
        return o;
    endfunction

    function automatic int unsigned pps_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
    parameter int unsigned W          = 8,
    parameter bit          START_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);

    logic [W-1:0] count;

    assign done = (count >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= START_FULL ? limit : '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick && !done) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pps_pkg::*;
#(
    parameter int unsigned CNT_W          = 8,
    parameter int unsigned VDD_GOOD_MAX_MS = 10,
    parameter int unsigned LAMP_DELAY_MS   = 181,
    parameter int unsigned LAMP_HOLD_MS    = 1,
    parameter int unsigned DRV_HOLD_MS     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic             vdd_good,
    input  logic             phase_done,
    input  logic             recov_done,
    output logic             phase_clr,
    output logic [CNT_W-1:0] phase_limit,
    output pps_out_t         outs
);

    pps_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_OFF:
                if (pwr_req && recov_done) state_nx = ST_RAMP;
            ST_RAMP:
                if (!pwr_req)        state_nx = ST_OFF;
                else if (vdd_good)   state_nx = ST_SETTLE;
                else if (phase_done) state_nx = ST_FAULT;
            ST_SETTLE:
                if (!vdd_good)       state_nx = ST_FAULT;
                else if (!pwr_req)   state_nx = ST_DRV_DN;
                else if (phase_done) state_nx = ST_ON;
            ST_ON:
                if (!vdd_good)       state_nx = ST_FAULT;
                else if (!pwr_req)   state_nx = ST_LAMP_DN;
            ST_LAMP_DN:
                if (!vdd_good)       state_nx = ST_FAULT;
                else if (phase_done) state_nx = ST_DRV_DN;
            ST_DRV_DN:
                if (phase_done)      state_nx = ST_OFF;
            ST_FAULT:
                if (!pwr_req)        state_nx = ST_OFF;
            default:                 state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        case (state)
            ST_RAMP:    phase_limit = CNT_W'(VDD_GOOD_MAX_MS);
            ST_SETTLE:  phase_limit = CNT_W'(LAMP_DELAY_MS);
            ST_LAMP_DN: phase_limit = CNT_W'(LAMP_HOLD_MS);
            ST_DRV_DN:  phase_limit = CNT_W'(DRV_HOLD_MS);
            default:    phase_limit = '0;
        endcase
    end

    assign phase_clr = (state_nx != state);
    assign outs      = pps_decode(state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int unsigned VDD_GOOD_MAX_MS = 10,
    parameter int unsigned LAMP_DELAY_MS   = 181,
    parameter int unsigned OFF_RECOVER_MS  = 151,
    parameter int unsigned LAMP_HOLD_MS    = 1,
    parameter int unsigned DRV_HOLD_MS     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic pwr_req,
    input  logic vdd_good,
    output logic vdd_en,
    output logic drv_en,
    output logic lamp_en,
    output logic supply_fault
);

    localparam int unsigned LIM_MAX =
        pps_max(pps_max(VDD_GOOD_MAX_MS, LAMP_DELAY_MS),
                pps_max(OFF_RECOVER_MS, pps_max(LAMP_HOLD_MS, DRV_HOLD_MS)));
    localparam int unsigned CNT_W = $clog2(LIM_MAX + 1);

    logic             phase_clr, phase_done, recov_done;
    logic [CNT_W-1:0] phase_limit;
    pps_out_t         outs;

    pps_fsm #(
        .CNT_W           (CNT_W),
        .VDD_GOOD_MAX_MS (VDD_GOOD_MAX_MS),
        .LAMP_DELAY_MS   (LAMP_DELAY_MS),
        .LAMP_HOLD_MS    (LAMP_HOLD_MS),
        .DRV_HOLD_MS     (DRV_HOLD_MS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_req     (pwr_req),
        .vdd_good    (vdd_good),
        .phase_done  (phase_done),
        .recov_done  (recov_done),
        .phase_clr   (phase_clr),
        .phase_limit (phase_limit),
        .outs        (outs)
    );

    pps_tick_timer #(.W(CNT_W), .START_FULL(1'b0)) u_phase_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase_clr),
        .tick  (ms_tick),
        .limit (phase_limit),
        .done  (phase_done)
    );

    pps_tick_timer #(.W(CNT_W), .START_FULL(1'b1)) u_recov_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (outs.supply),
        .tick  (ms_tick),
        .limit (CNT_W'(OFF_RECOVER_MS)),
        .done  (recov_done)
    );

    assign vdd_en       = outs.supply;
    assign drv_en       = outs.drive;
    assign lamp_en      = outs.lamp;
    assign supply_fault = outs.fault;

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int unsigned OFF_RECOVER_MS = 151
) (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic pwr_req,
    input logic vdd_good,
    input logic vdd_en,
    input logic drv_en,
    input logic lamp_en,
    input logic supply_fault
);

    localparam int unsigned CW = $clog2(OFF_RECOVER_MS + 1);

    logic [CW-1:0] off_ticks;

    always_ff @(posedge clk) begin
        if (rst)                    off_ticks <= CW'(OFF_RECOVER_MS);
        else if (vdd_en)            off_ticks <= '0;
        else if (ms_tick && off_ticks < CW'(OFF_RECOVER_MS))
                                    off_ticks <= off_ticks + 1'b1;
    end

    // R12
    lamp_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_en |-> drv_en);

    // R12
    drive_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> vdd_en);

    // R3
    drive_after_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> $past(vdd_good));

    // R11
    good_loss_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_en && !vdd_good) |=> (supply_fault && !vdd_en));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_fault && pwr_req) |=> supply_fault);

    // R6
    lamp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_en && !pwr_req) |=> !lamp_en);

    // R9
    recovery_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vdd_en) |-> (off_ticks >= CW'(OFF_RECOVER_MS)));

endmodule

bind panel_pwr_seq pps_checker #(.OFF_RECOVER_MS(OFF_RECOVER_MS)) u_pps_chk (
    .clk          (clk),
    .rst          (rst),
    .ms_tick      (ms_tick),
    .pwr_req      (pwr_req),
    .vdd_good     (vdd_good),
    .vdd_en       (vdd_en),
    .drv_en       (drv_en),
    .lamp_en      (lamp_en),
    .supply_fault (supply_fault)
);

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;

    localparam int VGM = 4;
    localparam int LDL = 6;
    localparam int REC = 5;
    localparam int LHD = 2;
    localparam int DHD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic pwr_req = 1'b0;
    logic vdd_good = 1'b0;
    logic vdd_en, drv_en, lamp_en, supply_fault;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_n = 0;
    int inv_bad = 0;
    int req_seen = 0;
    int good_seen = 0;
    int ramp_cycles = 3;
    bit sup_ok = 1'b1;
    int rise_snap[4], fall_snap[4], rise_cyc[4], fall_cyc[4], rise_cnt[4];
    logic prev[4];

    always #2.5 clk = ~clk;

    panel_pwr_seq #(
        .VDD_GOOD_MAX_MS (VGM),
        .LAMP_DELAY_MS   (LDL),
        .OFF_RECOVER_MS  (REC),
        .LAMP_HOLD_MS    (LHD),
        .DRV_HOLD_MS     (DHD)
    ) u_panel_pwr_seq (
        .clk          (clk),
        .rst          (rst),
        .ms_tick      (ms_tick),
        .pwr_req      (pwr_req),
        .vdd_good     (vdd_good),
        .vdd_en       (vdd_en),
        .drv_en       (drv_en),
        .lamp_en      (lamp_en),
        .supply_fault (supply_fault)
    );

    function automatic logic outv(int i);
        case (i)
            0: return vdd_en;
            1: return drv_en;
            2: return lamp_en;
            default: return supply_fault;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_lvl(int i, logic lvl);
        int n = 0;
        while (outv(i) !== lvl && n < 4000) begin
            @(negedge clk); #1;
            n++;
        end
    endtask

    task automatic set_req(logic v);
        @(posedge clk); #1;
        pwr_req = v;
        req_seen = cyc + 1;
    endtask

    // tick: one cycle high every four cycles
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 ms_tick = 1'b1;
            @(posedge clk);
            #1 ms_tick = 1'b0;
        end
    end

    // logic supply model
    initial begin
        int scnt = 0;
        forever begin
            logic nv;
            @(posedge clk); #1;
            if (vdd_en === 1'b1) scnt++;
            else scnt = 0;
            nv = sup_ok && (vdd_en === 1'b1) && (scnt >= ramp_cycles);
            if (nv !== vdd_good) good_seen = cyc + 1;
            vdd_good = nv;
        end
    end

    // output monitor at falling edges
    initial begin
        for (int i = 0; i < 4; i++) begin
            prev[i] = 1'b0; rise_cnt[i] = 0;
            rise_snap[i] = 0; fall_snap[i] = 0; rise_cyc[i] = 0; fall_cyc[i] = 0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < 4; i++) begin
                logic v;
                v = outv(i);
                if (v === 1'b1 && prev[i] !== 1'b1) begin
                    rise_snap[i] = tick_n; rise_cyc[i] = cyc; rise_cnt[i]++;
                end
                if (v !== 1'b1 && prev[i] === 1'b1) begin
                    fall_snap[i] = tick_n; fall_cyc[i] = cyc;
                end
                prev[i] = v;
            end
            // R12 invariant
            if ((lamp_en && !drv_en) || (drv_en && !vdd_en)) inv_bad++;
            if (ms_tick) tick_n++;
        end
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lamp_before, drv_before;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {vdd_en, drv_en, lamp_en, supply_fault}, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 outputs after reset", {vdd_en, drv_en, lamp_en, supply_fault}, 0);

        // normal power-up, first start needs no recovery wait
        ramp_cycles = 3;
        set_req(1'b1);
        wait_lvl(0, 1'b1);
        chk("R2 supply on cycle", rise_cyc[0], req_seen + 1);
        wait_lvl(1, 1'b1);
        chk("R3 drive on after good", rise_cyc[1], good_seen + 1);
        wait_lvl(2, 1'b1);
        chk("R5 lamp delay ticks", rise_snap[2] - rise_snap[1], LDL);
        repeat (10) @(negedge clk);
        #1;
        chk("R5 all on", {vdd_en, drv_en, lamp_en, supply_fault}, 4'b1110);

        // power-down in reverse order, with re-request during it
        set_req(1'b0);
        wait_lvl(2, 1'b0);
        chk("R6 lamp off cycle", fall_cyc[2], req_seen + 1);
        chk("R6 drive kept while lamp off", drv_en, 1);
        lamp_before = rise_cnt[2];
        set_req(1'b1);
        wait_lvl(1, 1'b0);
        chk("R6 lamp hold ticks", fall_snap[1] - fall_snap[2], LHD);
        chk("R8 lamp stays off", rise_cnt[2], lamp_before);
        wait_lvl(0, 1'b0);
        chk("R6 drive hold ticks", fall_snap[0] - fall_snap[1], DHD);
        wait_lvl(0, 1'b1);
        chk("R9 recovery ticks", rise_snap[0] - fall_snap[0], REC);

        // abort while waiting for the lamp
        wait_lvl(1, 1'b1);
        repeat (5) @(negedge clk);
        lamp_before = rise_cnt[2];
        set_req(1'b0);
        wait_lvl(1, 1'b0);
        chk("R7 drive off on abort", fall_cyc[1], req_seen + 1);
        wait_lvl(0, 1'b0);
        chk("R7 supply after drive hold", fall_snap[0] - fall_snap[1], DHD);
        chk("R7 lamp never on", rise_cnt[2], lamp_before);

        // abort during the supply ramp
        ramp_cycles = 100000;
        drv_before = rise_cnt[1];
        set_req(1'b1);
        wait_lvl(0, 1'b1);
        chk("R9 restart after recovery", rise_snap[0] - fall_snap[0] >= REC, 1);
        repeat (3) @(negedge clk);
        set_req(1'b0);
        wait_lvl(0, 1'b0);
        chk("R7 supply off on ramp abort", fall_cyc[0], req_seen + 1);
        chk("R7 drive never on", rise_cnt[1], drv_before);

        // supply never good: fault
        set_req(1'b1);
        wait_lvl(0, 1'b1);
        wait_lvl(3, 1'b1);
        chk("R4 fault timeout ticks", rise_snap[3] - rise_snap[0], VGM);
        chk("R4 supply drops with fault", fall_cyc[0], rise_cyc[3]);
        repeat (40) @(negedge clk);
        #1;
        chk("R10 fault held", {vdd_en, drv_en, lamp_en, supply_fault}, 4'b0001);
        set_req(1'b0);
        wait_lvl(3, 1'b0);
        chk("R10 fault clears", fall_cyc[3], req_seen + 1);

        // supply lost while lamp on
        ramp_cycles = 3;
        set_req(1'b1);
        wait_lvl(2, 1'b1);
        repeat (3) @(negedge clk);
        #1 sup_ok = 1'b0;
        wait_lvl(3, 1'b1);
        chk("R11 fault on good loss", rise_cyc[3], good_seen + 1);
        chk("R11 lamp drops", fall_cyc[2], rise_cyc[3]);
        chk("R11 drive drops", fall_cyc[1], rise_cyc[3]);
        chk("R11 supply drops", fall_cyc[0], rise_cyc[3]);
        set_req(1'b0);
        sup_ok = 1'b1;
        wait_lvl(3, 1'b0);

        chk("R12 enable ordering violations", inv_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule